// File: doc/BRIEF.md
# Bit-Slip Serial-to-Parallel Deserializer

This block turns a serial bit stream into 4-bit parallel words. It runs on the bit clock, so one bit arrives per cycle. A select input picks one of two serial inputs. The second input is meant for looping back data from a paired serializer during test. The selected bit goes into a shift register and is also sent back out, registered once, on a serial output. An internal counter divides the bit clock. It produces one strobe every fourth bit and another every eighth bit, and on the wrap it selects it loads the parallel word.

Word alignment is adjusted with an asynchronous realign request. After synchronization, each request held high for at least two sampled cycles makes the divider hold its count for one bit clock. The word boundary then moves one bit later in the stream, so a bit that would have come out on lane n comes out on lane n-1. A wide-mode input makes the parallel word update only on the eight-bit wrap, so two of these blocks can share an 8-bit conversion. An asynchronous active-low reset, released synchronously, puts the divider and all registers into a known state so that several blocks can start in step.

Top module: `bitslip_deser`

## Requirements
- R1: Within each word, the bit sampled first appears on lane 0 of `word_q`, the next on lane 1, and so on up to lane 3 for the last bit.
- R2: `tick4` is high for one cycle in every four bit clocks when no slip occurs. The first pulse comes in the fourth active cycle after reset is released internally.
- R3: `tick8` is high for one cycle in every eight bit clocks, and only in a cycle in which `tick4` is also high.
- R4: With `wide_mode` low, `word_q` loads on the edge that closes a `tick4` cycle, and keeps its value on every other edge.
- R5: With `wide_mode` high, `word_q` loads only on the edge that closes a `tick8` cycle. That word holds the last four bits received.
- R6: A `realign` level that is sampled high on two consecutive edges causes exactly one slip. On the third edge after the first high sample, the divider does not advance, which delays the next word boundary by one bit.
- R7: A `realign` pulse that is sampled high on only one edge causes no slip.
- R8: A `realign` level held high for any length of time causes only one slip. A new slip needs the input to go low and then high again.
- R9: `src_sel` = 0 selects `sin_a` and `src_sel` = 1 selects `sin_b` as the bit that is shifted in.
- R10: `sout` equals the selected serial bit from the previous bit clock.
- R11: While `rst_n` is low, `word_q`, `sout`, `tick4` and `tick8` are all 0. Reset is released internally on the second rising edge after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| sin_a | input | 1 | Serial data input A |
| sin_b | input | 1 | Serial data input B (loopback) |
| src_sel | input | 1 | 0 selects A, 1 selects B |
| realign | input | 1 | Asynchronous word-boundary slip request |
| wide_mode | input | 1 | 1 = load word every eight bits |
| word_q | output | 4 | Parallel word, lane 0 holds the earliest bit |
| tick4 | output | 1 | Divide-by-4 strobe |
| tick8 | output | 1 | Divide-by-8 strobe |
| sout | output | 1 | Selected serial bit, delayed one clock |

## Verification
`sout` is due one edge after its input bit. A word is due on the edge that closes the strobe cycle in which its fourth bit was presented, and the strobes come straight from the counter value that edge leaves behind. A realign level first takes effect on the third edge after the input is first sampled high, and it then holds the count across exactly one edge. The bench drives inputs on falling edges and advances its arithmetic expectation on each rising edge. It compares every output at the following falling edge, so each result is sampled in the cycle in which it is due.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef enum logic {
    SRC_PRIMARY  = 1'b0,
    SRC_LOOPBACK = 1'b1
  } src_sel_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/bsd_rst_sync.sv
module bsd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/bsd_slip_detect.sv
module bsd_slip_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_req,
  output logic slip_o
);
  logic [SYNC_STAGES-1:0] meta_q, meta_d;
  logic                   synced;
  logic                   prev_q, prev_d;
  logic                   held_q, held_d;

  assign synced = meta_q[SYNC_STAGES-1];

  always_comb begin
    meta_d = {meta_q[SYNC_STAGES-2:0], async_req};
    prev_d = synced;
    held_d = prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      prev_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      prev_q <= prev_d;
      held_q <= held_d;
    end
  end

  // two consecutive high samples, first time only
  assign slip_o = synced & prev_q & ~held_q;

  // R8: a held level cannot produce back-to-back slips
  a_r8_single_slip: assert property (@(posedge clk) disable iff (!rst_n)
    slip_o |=> !slip_o);
endmodule

// File: rtl/bsd_divider.sv
module bsd_divider #(
  parameter int unsigned WORD_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slip,
  input  logic wide_mode,
  output logic wrap_narrow,
  output logic wrap_wide,
  output logic load_o
);
  localparam int unsigned LO_W  = $clog2(WORD_W);
  localparam int unsigned CNT_W = LO_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             advance;

  assign advance = ~slip;

  always_comb begin
    cnt_d = cnt_q;
    if (advance) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wrap_narrow = (&cnt_q[LO_W-1:0]) & advance;
  assign wrap_wide   = (&cnt_q) & advance;
  assign load_o      = wide_mode ? wrap_wide : wrap_narrow;

  // R2: narrow strobes never come on adjacent cycles
  a_r2_narrow_gap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_narrow |=> !wrap_narrow);
  // R6: a slip swallows exactly this edge
  a_r6_swallow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> (cnt_q == $past(cnt_q)));
  // R3: wide strobes never come on adjacent cycles
  a_r3_wide_gap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_wide |=> !wrap_wide);
endmodule

// File: rtl/bsd_shifter.sv
module bsd_shifter #(
  parameter int unsigned WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              load,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q, sr_d;
  logic [WORD_W-1:0] par_q, par_d;

  always_comb begin
    sr_d  = {ser_in, sr_q[WORD_W-1:1]};
    par_d = par_q;
    if (load) par_d = sr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      par_q <= '0;
    end else begin
      sr_q  <= sr_d;
      par_q <= par_d;
    end
  end

  assign word_o = par_q;

  // R4: the word holds between loads
  a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_o));
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
  parameter int unsigned WORD_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sin_a,
  input  logic              sin_b,
  input  logic              src_sel,
  input  logic              realign,
  input  logic              wide_mode,
  output logic [WORD_W-1:0] word_q,
  output logic              tick4,
  output logic              tick8,
  output logic              sout
);
  import bsd_pkg::*;

  logic     rst_int_n;
  logic     slip;
  logic     load;
  logic     sel_bit;
  logic     sout_q;
  src_sel_e src;

  bsd_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  bsd_slip_detect #(.SYNC_STAGES(SYNC_STAGES)) u_slip (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .async_req (realign),
    .slip_o    (slip)
  );

  bsd_divider #(.WORD_W(WORD_W)) u_div (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .slip        (slip),
    .wide_mode   (wide_mode),
    .wrap_narrow (tick4),
    .wrap_wide   (tick8),
    .load_o      (load)
  );

  assign src     = src_sel_e'(src_sel);
  assign sel_bit = (src == SRC_LOOPBACK) ? sin_b : sin_a;

  bsd_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ser_in (sel_bit),
    .load   (load),
    .word_o (word_q)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sout_q <= 1'b0;
    else            sout_q <= sel_bit;
  end

  assign sout = sout_q;

  // R3: the eight-bit strobe coincides with a four-bit strobe
  a_r3_wide_in_narrow: assert property (@(posedge clk) disable iff (!rst_int_n)
    tick8 |-> tick4);
  // R11: nothing strobes while reset is held
  a_r11_quiet_reset: assert property (@(posedge clk)
    !rst_n |-> (!tick4 && !tick8));
endmodule

// File: tb/bitslip_deser_test.sv
module bitslip_deser_test;
  logic       clk = 1'b0;
  logic       rst_n, sin_a, sin_b, src_sel, realign, wide_mode;
  logic [3:0] word_q;
  logic       tick4, tick8, sout;

  int tests = 0, fails = 0;
  bit done = 0;
  string phase = "R11";

  logic [2:0]  m_cnt;
  logic [3:0]  m_sr, m_word;
  logic        m_sout;
  logic [3:0]  m_h;     // realign sample history, [0] newest
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  bitslip_deser uut (
    .clk(clk), .rst_n(rst_n), .sin_a(sin_a), .sin_b(sin_b),
    .src_sel(src_sel), .realign(realign), .wide_mode(wide_mode),
    .word_q(word_q), .tick4(tick4), .tick8(tick8), .sout(sout)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
    end
  endtask

  function automatic logic m_slip();
    return m_h[1] & m_h[2] & ~m_h[3];
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_sr = 0; m_word = 0; m_sout = 0; m_h = 0;
  endtask

  task automatic check_all();
    logic e4;
    e4 = (m_cnt[1:0] == 2'b11) && !m_slip();
    chk(wide_mode ? "R5 word" : "R1 word", word_q, m_word);
    chk("R2 tick4", tick4, e4);
    chk("R3 tick8", tick8, (m_cnt == 3'b111) && !m_slip());
    chk(src_sel ? "R9 sout" : "R10 sout", sout, m_sout);
  endtask

  // drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(input logic req);
    logic bit_now, slip_now, ld;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sin_a = lfsr[0];
    sin_b = lfsr[7];
    realign = req;
    @(posedge clk);
    bit_now  = src_sel ? sin_b : sin_a;
    slip_now = m_slip();
    ld = wide_mode ? ((m_cnt == 3'b111) && !slip_now)
                   : ((m_cnt[1:0] == 2'b11) && !slip_now);
    m_sr = {bit_now, m_sr[3:1]};
    if (ld) m_word = m_sr;
    m_sout = bit_now;
    if (!slip_now) m_cnt = m_cnt + 3'd1;
    m_h = {m_h[2:0], req};
    @(negedge clk);
    check_all();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  task automatic pulse(input int len);
    for (int i = 0; i < len; i++) step(1'b1);
    run(12);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sin_a = 0; sin_b = 0; realign = 0;
    model_reset();
    @(negedge clk);
    // R11: outputs cleared while reset is low
    phase = "R11";
    chk("R11 word", word_q, 0);
    chk("R11 sout", sout, 0);
    chk("R11 tick4", tick4, 0);
    chk("R11 tick8", tick8, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sin_a = 0; sin_b = 0; src_sel = 0; realign = 0; wide_mode = 0;
    do_reset();

    // R2: first strobe in the fourth active cycle
    phase = "R2";
    run(3);
    chk("R2 first tick4", tick4, 1);

    // R1, R4: narrow words from input A
    phase = "R1";
    run(40);
    // R9: switch to loopback input
    phase = "R9";
    src_sel = 1;
    run(40);
    src_sel = 0;

    // R7: single-sample pulse has no effect
    phase = "R7";
    pulse(1);
    // R6: each two-sample pulse slips one bit; walk through every offset
    phase = "R6";
    for (int k = 0; k < 5; k++) pulse(2 + k % 2);
    // R8: long level slips once only
    phase = "R8";
    pulse(15);

    // R5: wide mode, with slips through all eight offsets
    phase = "R5";
    wide_mode = 1;
    run(48);
    for (int k = 0; k < 8; k++) pulse(2);
    src_sel = 1;
    run(24);
    wide_mode = 0;
    run(8);

    // R11: reset again mid-stream and restart
    do_reset();
    phase = "R4";
    run(20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule